// File: doc/BRIEF.md
# Level-Priority Interrupt Arbiter

This block chooses which of N local interrupt sources is presented to a processor core. Every source supplies four things: a pending flag, an enable flag, a vector-mode flag and an 8-bit control byte. A shared configuration byte sets how many of the top control bits form the interrupt level. The control bits that remain below the level field form a priority within that level. Only six control bits are implemented. The two lowest bits of every control byte have no effect.

A tree of pairwise comparators picks one winner from the sources that are both pending and enabled. The winner is gated twice. Its level must reach a threshold, and it must be strictly above the level the core is servicing now, which comes in as an input. The block registers the result as a request flag and a 21-bit request word. The word packs the source index, the vector-mode flag and the effective level. Bus access to the per-source fields and edge detection on the raw interrupt lines happen outside this block.

Top module: `irq_level_arb`

## Requirements
- R1: The level-bit count is cfg[4:1], saturated at 6, so any value from 6 to 15 behaves as 6.
- R2: With a level-bit count of zero the effective level is 255, and the priority is control bits [7:2] read as an unsigned number.
- R3: With a level-bit count L from 1 to 6, the effective level keeps the top L control bits in place and forces every bit below them to 1.
- R4: The priority is formed from control bits [7:2] that lie below the level field, right-justified. It is 0 when L is 6. Control bits [1:0] never change the outcome.
- R5: A source is considered only if both its pending bit and its enable bit are 1.
- R6: Among the sources considered, the highest level wins. On equal levels the higher priority wins. On equal level and priority the higher source index wins.
- R7: A request is raised only if the winner's level is greater than or equal to thresh and strictly greater than act_lvl.
- R8: irq_word holds the source index in [11:0], that source's vector-mode bit in [12] and its effective level in [20:13].
- R9: irq_req and irq_word are registered. They show the result for the inputs that were present at the previous rising clock edge.
- R10: When no source qualifies, irq_req is 0 and irq_word is 0.
- R11: While rst is high at a clock edge, irq_req and irq_word are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pend | input | N | Pending flag per source |
| en | input | N | Enable flag per source |
| vmode | input | N | Vector-mode flag per source |
| ctl | input | 8*N | Control byte per source; source k uses bits [8k+7:8k] |
| cfg | input | 8 | Configuration; bits [4:1] set the level-bit count |
| thresh | input | 8 | Level threshold |
| act_lvl | input | 8 | Level currently being serviced by the core |
| irq_req | output | 1 | Registered interrupt request |
| irq_word | output | 21 | Registered request word (index, vector flag, level) |

## Verification
Both outputs are due exactly one rising edge after the inputs that produce them. The bench changes inputs only on falling edges. It compares the outputs at the next falling edge, after one rising edge has passed. Immediately after each input change, and before any rising edge, it also confirms that the outputs still show the previous result. This detects a missing register as well as an extra one.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int IDX_W  = 12;
  localparam int LVL_W  = 8;
  localparam int WORD_W = IDX_W + 1 + LVL_W;

  typedef struct packed {
    logic             valid;
    logic [LVL_W-1:0] lvl;
    logic [LVL_W-1:0] prio;
    logic [IDX_W-1:0] idx;
    logic             vec;
  } cand_t;
endpackage

// File: rtl/ctl_decode.sv
module ctl_decode #(
  parameter int CTL_W    = 8,
  parameter int CTL_IMPL = 6
) (
  input  logic [CTL_W-1:0] ctl_i,
  input  logic [2:0]       nl_i,
  output logic [CTL_W-1:0] lvl_o,
  output logic [CTL_W-1:0] prio_o
);
  localparam int LOW_UNIMPL = CTL_W - CTL_IMPL;

  always_comb begin
    // level: top nl bits kept, all lower bits set (nl==0 gives all ones)
    for (int b = 0; b < CTL_W; b++)
      lvl_o[b] = (b >= CTL_W - int'(nl_i)) ? ctl_i[b] : 1'b1;
    // priority: implemented bits below the level field, right-justified
    prio_o = '0;
    for (int b = 0; b < CTL_IMPL; b++)
      prio_o[b] = (b < CTL_IMPL - int'(nl_i)) ? ctl_i[b+LOW_UNIMPL] : 1'b0;
  end
endmodule

// File: rtl/pair_pick.sv
module pair_pick
  import irq_arb_pkg::*;
(
  input  cand_t lo_i,   // covers the lower source indices
  input  cand_t hi_i,   // covers the higher source indices
  output cand_t win_o
);
  logic take_hi;

  always_comb begin
    if (!hi_i.valid)                take_hi = 1'b0;
    else if (!lo_i.valid)           take_hi = 1'b1;
    else if (hi_i.lvl != lo_i.lvl)  take_hi = hi_i.lvl > lo_i.lvl;
    else                            take_hi = hi_i.prio >= lo_i.prio;
    win_o = take_hi ? hi_i : lo_i;
  end
endmodule

// File: rtl/pick_tree.sv
module pick_tree
  import irq_arb_pkg::*;
#(
  parameter int N = 16
) (
  input  cand_t leaf_i [N],
  output cand_t win_o
);
  localparam int LG = (N <= 1) ? 1 : $clog2(N);
  localparam int P  = 1 << LG;
  localparam int NODES = 2 * P - 1;

  cand_t node [NODES];

  genvar k;
  generate
    for (k = 0; k < P; k++) begin : g_leaf
      if (k < N) begin : g_real
        assign node[P-1+k] = leaf_i[k];
      end else begin : g_pad
        assign node[P-1+k] = '0;
      end
    end
    for (k = 0; k < P - 1; k++) begin : g_node
      pair_pick u_pp (
        .lo_i  (node[2*k+1]),
        .hi_i  (node[2*k+2]),
        .win_o (node[k])
      );
    end
  endgenerate

  assign win_o = node[0];
endmodule

// File: rtl/irq_level_arb.sv
module irq_level_arb
  import irq_arb_pkg::*;
#(
  parameter int N = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N-1:0]        pend,
  input  logic [N-1:0]        en,
  input  logic [N-1:0]        vmode,
  input  logic [8*N-1:0]      ctl,
  input  logic [7:0]          cfg,
  input  logic [7:0]          thresh,
  input  logic [7:0]          act_lvl,
  output logic                irq_req,
  output logic [WORD_W-1:0]   irq_word
);
  localparam int CTL_W    = 8;
  localparam int CTL_IMPL = 6;

  logic [3:0] nl_raw;
  logic [2:0] nl;
  assign nl_raw = cfg[4:1];
  assign nl     = (nl_raw > 4'(CTL_IMPL)) ? 3'(CTL_IMPL) : nl_raw[2:0];

  cand_t leaf [N];
  cand_t win;

  genvar s;
  generate
    for (s = 0; s < N; s++) begin : g_src
      logic [CTL_W-1:0] lvl_s, prio_s;
      ctl_decode #(.CTL_W(CTL_W), .CTL_IMPL(CTL_IMPL)) u_dec (
        .ctl_i  (ctl[s*CTL_W +: CTL_W]),
        .nl_i   (nl),
        .lvl_o  (lvl_s),
        .prio_o (prio_s)
      );
      assign leaf[s].valid = pend[s] & en[s];
      assign leaf[s].lvl   = lvl_s;
      assign leaf[s].prio  = prio_s;
      assign leaf[s].idx   = IDX_W'(s);
      assign leaf[s].vec   = vmode[s];
    end
  endgenerate

  pick_tree #(.N(N)) u_tree (
    .leaf_i (leaf),
    .win_o  (win)
  );

  logic fire;
  assign fire = win.valid && (win.lvl >= thresh) && (win.lvl > act_lvl);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req  <= 1'b0;
      irq_word <= '0;
    end else begin
      irq_req  <= fire;
      irq_word <= fire ? {win.lvl, win.vec, win.idx} : '0;
    end
  end
endmodule

// File: rtl/irq_level_arb_chk.sv
module irq_level_arb_chk #(
  parameter int N = 16
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] pend,
  input logic [N-1:0] en,
  input logic [7:0]   thresh,
  input logic [7:0]   act_lvl,
  input logic         irq_req,
  input logic [20:0]  irq_word
);
  // R7
  gate_level_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_word[20:13] >= $past(thresh)) && (irq_word[20:13] > $past(act_lvl)));

  // R10
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_req |-> irq_word == '0);

  // R5
  need_cand_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(pend & en) == '0) |-> !irq_req);

  // R8
  idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_word[11:0] < 12'(N)));

  // R11
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (!irq_req && irq_word == '0));
endmodule

bind irq_level_arb irq_level_arb_chk #(.N(N)) u_chk (.*);

// File: tb/sim_irq_level_arb.sv
module sim_irq_level_arb;
  localparam int N = 16;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [N-1:0]   pend = '0, en = '0, vmode = '0;
  logic [8*N-1:0] ctl = '0;
  logic [7:0]     cfg = '0, thresh = '0, act_lvl = '0;
  logic           irq_req;
  logic [20:0]    irq_word;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [21:0] prev_exp;

  always #10 clk = ~clk;

  irq_level_arb #(.N(N)) u0 (
    .clk(clk), .rst(rst), .pend(pend), .en(en), .vmode(vmode), .ctl(ctl),
    .cfg(cfg), .thresh(thresh), .act_lvl(act_lvl),
    .irq_req(irq_req), .irq_word(irq_word));

  function automatic logic [21:0] model();
    int nl, pw, best;
    logic [7:0] bl, bp, lv, pr, c;
    nl = int'(cfg[4:1]);
    if (nl > 6) nl = 6;
    pw = 6 - nl;
    best = -1; bl = 0; bp = 0;
    for (int k = 0; k < N; k++) begin
      c = ctl[8*k +: 8];
      lv = (nl == 0) ? 8'hFF : 8'(((c >> (8 - nl)) << (8 - nl)) | (8'hFF >> nl));
      pr = (pw == 0) ? 8'h0 : 8'((c >> 2) & ((1 << pw) - 1));
      if (pend[k] && en[k]) begin
        if (best < 0 || lv > bl || (lv == bl && pr >= bp)) begin
          best = k; bl = lv; bp = pr;
        end
      end
    end
    if (best >= 0 && bl >= thresh && bl > act_lvl)
      return {1'b1, bl, vmode[best], 12'(best)};
    return '0;
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [21:0] act, input logic [21:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // inputs already set at a falling edge; verify hold then one-edge result
  task automatic step(input string tag);
    logic [21:0] e;
    e = model();
    #1;
    check({irq_req, irq_word} == prev_exp, "R9 hold", {irq_req, irq_word}, prev_exp);
    @(posedge clk); @(negedge clk);
    check({irq_req, irq_word} == e, tag, {irq_req, irq_word}, e);
    prev_exp = e;
  endtask

  task automatic set_ctl(input int k, input logic [7:0] v);
    ctl[8*k +: 8] = v;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset state
    check({irq_req, irq_word} == 22'h0, "R11 reset", {irq_req, irq_word}, 22'h0);
    rst = 1'b0;
    prev_exp = '0;

    // R10: nothing pending
    step("R10 idle");
    // R5: pending but disabled
    pend = 16'h0010; set_ctl(4, 8'hC0); cfg = 8'h04;
    step("R5 disabled");
    // R5/R8: enabled, vector flag set
    en = 16'h0010; vmode = 16'h0010;
    step("R8 word");
    // R2: zero level bits gives 255, priority picks
    cfg = 8'h00; pend = 16'h0028; en = 16'h0028; vmode = '0;
    set_ctl(3, 8'hFC); set_ctl(5, 8'h04);
    step("R2 nl0");
    // R6: equal level and priority, higher index wins
    set_ctl(3, 8'h80); set_ctl(5, 8'h80);
    step("R6 tie");
    // R4: low unimplemented bits ignored
    set_ctl(3, 8'h83);
    step("R4 lowbits");
    // R1: cfg[4:1]=15 saturates to 6, priority 0
    cfg = 8'h1E; set_ctl(3, 8'hA8); set_ctl(5, 8'hA4);
    step("R1 cap");
    // R3: level left-justified with ones below
    cfg = 8'h06; set_ctl(3, 8'h40); set_ctl(5, 8'h20);
    step("R3 level");
    // R7: threshold equal passes, active equal blocks
    thresh = 8'h5F; act_lvl = 8'h00;
    step("R7 thresh eq");
    thresh = 8'h00; act_lvl = 8'h5F;
    step("R7 active eq");
    act_lvl = 8'h5E;
    step("R7 active below");
    act_lvl = 8'h00;

    // random mix
    for (int i = 0; i < 400; i++) begin
      pend = N'($urandom); en = N'($urandom); vmode = N'($urandom);
      for (int k = 0; k < N; k++) begin
        // narrow control values so ties happen often
        set_ctl(k, ($urandom % 4 == 0) ? 8'($urandom) : 8'({$urandom % 3, 6'h0}));
      end
      cfg = 8'($urandom);
      thresh = ($urandom % 3 == 0) ? 8'($urandom) : 8'h0;
      act_lvl = ($urandom % 3 == 0) ? 8'($urandom) : 8'h0;
      step("R6 random");
    end

    // R11: reset mid-run clears outputs
    pend = '1; en = '1; thresh = 0; act_lvl = 0;
    step("R6 all");
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check({irq_req, irq_word} == 22'h0, "R11 midrun", {irq_req, irq_word}, 22'h0);
    finish_run();
  end
endmodule